// File: doc/BRIEF.md
# RF Output Settle Gate

This block holds an RF output stage off while the channel synthesizer acquires lock. A pulse on `restart` marks either a cold power-up or a return from standby. The block then clears its delay count and keeps `rf_en` low. It counts ticks of a 31.25 kHz reference, and `rf_en` rises once 8192 ticks have been seen, which is about 262 ms. Supply sensing happens elsewhere, so `restart` arrives here as a one-cycle digital pulse.

A two-bit production test code changes how the gate behaves. With this code, a test fixture can:
- skip the delay altogether;
- hold the output off whatever the count is;
- shorten the delay by a factor of 64.

Selecting the short delay also restarts the count, so a tester always sees a full short window. All pins are plain control signals, with no streaming data and no handshake. Every input is sampled on the rising edge of `clk`.

Top module: `rf_settle_gate`

## Requirements
- R1: While `rst_n` is low, and after it is released with no reference tick, `rf_en` is 0 for test codes 00, 10 and 11.
- R2: A `restart` pulse clears the delay count. Under test code 00, `rf_en` stays 0 until 8192 cycles with `ref_tick` high have been sampled after the pulse, and it is 1 right after the 8192nd. Cycles with `ref_tick` low do not advance the count.
- R3: Once the terminal count is reached, the count saturates. Under code 00, `rf_en` then stays 1 through further ticks and idle cycles until the next `restart`.
- R4: Test code 01 (`test_code[1]`=0, `test_code[0]`=1) drives `rf_en` to 1 in the same cycle, whatever the count. The count keeps running underneath.
- R5: Test code 10 drives `rf_en` to 0 in the same cycle, whatever the count. Ticks are still counted while this code is held.
- R6: Under test code 11 the terminal count is 128 ticks, which is 8192/64.
- R7: A change of `test_code` into 11 from any other code clears the count and forces `rf_en` to 0 in that same cycle. Holding 11 afterwards does not clear the count again.
- R8: Moving from code 10 to code 00 makes `rf_en` 1 only if the terminal count was already reached. Otherwise `rf_en` stays 0 until it is reached.
- R9: A clear caused by `restart` or by entry into code 11 takes priority over a `ref_tick` sampled in the same cycle, and that tick is not counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_tick | input | 1 | One-cycle strobe per reference period |
| restart | input | 1 | One-cycle pulse on power-up or standby exit |
| test_code | input | 2 | Test code: 00 timed, 01 bypass, 10 forced off, 11 fast |
| rf_en | output | 1 | RF output enable |

## Verification
Two pairs of events can land on the same clock edge, and each pair is forced on purpose:
- A clear and a reference tick. The bench raises `restart` and `ref_tick` together, or switches the code to 11 in the very cycle a tick is present.
- A pending clear and the output mux. A code-11 entry happens while the gate is already released.

For the first pair, the bench counts the ticks that follow. `rf_en` must rise exactly 8192 (or 128) ticks later and not one tick sooner, which shows the coincident tick was dropped. For the second pair, the bench samples `rf_en` between the code change and the next edge and expects it low at once. A sweep of fast-mode tick counts around 128 pins down the exact terminal count.

// File: rtl/rf_settle_pkg.sv
package rf_settle_pkg;

  typedef enum logic [1:0] {
    GM_TIMED    = 2'b00,
    GM_BYPASS   = 2'b01,
    GM_FORCEOFF = 2'b10,
    GM_FAST     = 2'b11
  } gate_mode_e;

endpackage

// File: rtl/rf_settle_mode.sv
module rf_settle_mode
  import rf_settle_pkg::*;
#(
  parameter int REF_TICKS   = 8192,
  parameter int FAST_FACTOR = 64,
  localparam int FAST_TICKS = REF_TICKS / FAST_FACTOR,
  localparam int CW         = $clog2(REF_TICKS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       test_code,
  output gate_mode_e       mode,
  output logic             fast_entry,
  output logic [CW-1:0]    limit
);

  gate_mode_e prev_mode;

  assign mode = gate_mode_e'(test_code);

  // previous code, used to spot a change into the fast code
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_mode <= GM_TIMED;
    else        prev_mode <= mode;
  end

  assign fast_entry = (mode == GM_FAST) && (prev_mode != GM_FAST);

  always_comb begin
    if (mode == GM_FAST) limit = CW'(FAST_TICKS);
    else                 limit = CW'(REF_TICKS);
  end

endmodule

// File: rtl/rf_settle_counter.sv
module rf_settle_counter #(
  parameter int REF_TICKS = 8192,
  localparam int CW       = $clog2(REF_TICKS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          clear,
  input  logic [CW-1:0] limit,
  output logic          done
);

  logic [CW-1:0] count;
  logic [CW-1:0] count_inc;

  assign count_inc = count + CW'(1);

  // a clear wins over a tick in the same cycle; the count saturates once done
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      done  <= 1'b0;
    end else if (clear) begin
      count <= '0;
      done  <= 1'b0;
    end else if (tick && !done) begin
      count <= count_inc;
      if (count_inc >= limit) done <= 1'b1;
    end
  end

endmodule

// File: rtl/rf_settle_out.sv
module rf_settle_out
  import rf_settle_pkg::*;
(
  input  gate_mode_e mode,
  input  logic       done,
  input  logic       fast_entry,
  output logic       rf_en
);

  always_comb begin
    unique case (mode)
      GM_BYPASS:   rf_en = 1'b1;
      GM_FORCEOFF: rf_en = 1'b0;
      GM_FAST:     rf_en = done && !fast_entry;
      default:     rf_en = done;
    endcase
  end

endmodule

// File: rtl/rf_settle_gate.sv
module rf_settle_gate
  import rf_settle_pkg::*;
#(
  parameter int REF_TICKS   = 8192,
  parameter int FAST_FACTOR = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_tick,
  input  logic       restart,
  input  logic [1:0] test_code,
  output logic       rf_en
);

  localparam int CW = $clog2(REF_TICKS + 1);

  gate_mode_e    mode;
  logic          fast_entry;
  logic [CW-1:0] limit;
  logic          done;

  rf_settle_mode #(
    .REF_TICKS  (REF_TICKS),
    .FAST_FACTOR(FAST_FACTOR)
  ) u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .test_code (test_code),
    .mode      (mode),
    .fast_entry(fast_entry),
    .limit     (limit)
  );

  rf_settle_counter #(
    .REF_TICKS(REF_TICKS)
  ) u_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (ref_tick),
    .clear(restart || fast_entry),
    .limit(limit),
    .done (done)
  );

  rf_settle_out u_out (
    .mode      (mode),
    .done      (done),
    .fast_entry(fast_entry),
    .rf_en     (rf_en)
  );

endmodule

// File: rtl/rf_settle_chk.sv
module rf_settle_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ref_tick,
  input logic       restart,
  input logic [1:0] test_code,
  input logic       rf_en
);

  assert_restart_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (!rf_en || test_code == 2'b01));

  assert_bypass_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    test_code == 2'b01 |-> rf_en);

  assert_forced_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    test_code == 2'b10 |-> !rf_en);

  assert_hold_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (test_code == 2'b00 && $past(test_code) == 2'b00 && $past(rf_en) && !$past(restart))
      |-> rf_en);

  assert_fast_entry_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (test_code == 2'b11 && $past(test_code) != 2'b11) |-> !rf_en);

  assert_rise_needs_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rf_en) && test_code[0] == test_code[1] && $past(test_code) == test_code)
      |-> $past(ref_tick));

endmodule

bind rf_settle_gate rf_settle_chk u_chk (.*);

// File: tb/tb_rf_settle_gate.sv
`timescale 1ns/1ps
module tb_rf_settle_gate;

  localparam int NT = 8192;
  localparam int FT = NT / 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_tick = 1'b0;
  logic       restart = 1'b0;
  logic [1:0] test_code = 2'b00;
  logic       rf_en;

  int total = 0;
  int bad = 0;
  bit ended = 0;

  always #2.5 clk = ~clk;

  rf_settle_gate dut (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick),
    .restart(restart), .test_code(test_code), .rf_en(rf_en)
  );

  task automatic check(input logic exp, input string req);
    total++;
    if (rf_en !== exp) begin
      bad++;
      $display("FAIL %s: rf_en=%b expected=%b at %0t", req, rf_en, exp, $time);
    end
  endtask

  task automatic run_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ref_tick = 1'b1;
    end
    @(negedge clk); ref_tick = 1'b0; #1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic pulse_restart(input logic with_tick);
    @(negedge clk); restart = 1'b1; ref_tick = with_tick;
    @(negedge clk); restart = 1'b0; ref_tick = 1'b0; #1;
  endtask

  task automatic set_code(input logic [1:0] c);
    @(negedge clk); test_code = c; #1;
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    total++; bad++;
    $display("FAIL watchdog: rf_en=%b expected=end of run", rf_en);
    finish_run();
  end

  initial begin
    idle(3);
    check(1'b0, "R1 in reset");
    @(negedge clk); rst_n = 1'b1; #1;
    idle(2);
    check(1'b0, "R1 after reset");

    // R2: full normal delay
    pulse_restart(1'b0);
    check(1'b0, "R2 after restart");
    run_ticks(NT - 1);
    check(1'b0, "R2 one tick short");
    run_ticks(1);
    check(1'b1, "R2 terminal");
    idle(50);
    check(1'b1, "R3 idle hold");
    run_ticks(300);
    check(1'b1, "R3 saturate");

    // R2: idle cycles do not advance
    pulse_restart(1'b0);
    run_ticks(8000);
    idle(500);
    run_ticks(NT - 8000 - 1);
    check(1'b0, "R2 idle not counted");
    run_ticks(1);
    check(1'b1, "R2 terminal after gaps");

    // R4 bypass
    pulse_restart(1'b0);
    set_code(2'b01);
    check(1'b1, "R4 bypass");
    run_ticks(10);
    check(1'b1, "R4 bypass hold");
    set_code(2'b00);
    check(1'b0, "R4 bypass released");

    // R5 force off, counting continues, R8 leave to 00 after done
    set_code(2'b10);
    check(1'b0, "R5 forced");
    run_ticks(NT - 10);
    check(1'b0, "R5 forced after terminal");
    set_code(2'b00);
    check(1'b1, "R8 leave forced done");

    // R8 leave forced before done
    pulse_restart(1'b0);
    set_code(2'b10);
    run_ticks(100);
    set_code(2'b00);
    check(1'b0, "R8 leave forced not done");

    // R7/R6 fast entry mid count
    set_code(2'b11);
    check(1'b0, "R7 entry");
    run_ticks(FT - 1);
    check(1'b0, "R6 fast short");
    run_ticks(1);
    check(1'b1, "R6 fast terminal");
    idle(10);
    check(1'b1, "R7 no re-clear while held");

    // R7 entry after done drops output at once
    set_code(2'b00);
    check(1'b1, "R3 done under 00");
    set_code(2'b11);
    check(1'b0, "R7 entry after done");
    run_ticks(FT);
    check(1'b1, "R6 fast after re-entry");

    // R9 restart with coincident tick
    set_code(2'b00);
    pulse_restart(1'b1);
    run_ticks(NT - 1);
    check(1'b0, "R9 restart tick dropped");
    run_ticks(1);
    check(1'b1, "R9 restart terminal");

    // R9 fast entry with coincident tick
    set_code(2'b00);
    @(negedge clk); test_code = 2'b11; ref_tick = 1'b1;
    @(negedge clk); ref_tick = 1'b0; #1;
    run_ticks(FT - 1);
    check(1'b0, "R9 entry tick dropped");
    run_ticks(1);
    check(1'b1, "R9 entry terminal");

    // R6 sweep of fast tick counts around the terminal value
    for (int k = FT - 8; k <= FT + 4; k++) begin
      pulse_restart(1'b0);
      run_ticks(k);
      check((k >= FT) ? 1'b1 : 1'b0, "R6 sweep");
    end

    finish_run();
  end

endmodule